// File: doc/BRIEF.md
# Byte-Wide Parallel Programming Target

This block is the device-side logic of a byte-wide parallel programming port. An external programmer presents a byte on an 8-bit bus together with a two-bit mode code and a byte-select bit, then raises a load strobe. On that rising edge the byte goes into one of four holding registers: the command register, the low address register, or the low or high half of a two-byte data register. A separate page-latch strobe copies the held data word into a small page buffer. A falling pulse on the active-low write strobe then starts whichever operation the command register selects. The block holds a ready/busy output low while that operation runs.

Two operations exist. Command `0x80` is a chip erase. It sets every flash word to `0xFFFF`. The EEPROM bytes are also set to `0xFF`, unless the preserve input is high. Command `0x10` writes the whole page buffer into one flash page and then refills the buffer with `0xFFFF`. The flash and EEPROM are modelled as internal register arrays. Each has a fixed power-up pattern and a fixed operation time. A combinational inspection port lets either array be viewed word by word.

The controller has three states. `ST_IDLE` is the only ready state. `ST_IDLE -> ST_ERASE` is taken on a write-strobe fall with the erase command. `ST_IDLE -> ST_PROG` is taken on a write-strobe fall with the write command. `ST_ERASE -> ST_IDLE` and `ST_PROG -> ST_IDLE` are taken when the down-counter reaches zero. The `ST_PROG` exit also clears the page buffer. A write-strobe fall with any other command leaves the controller in `ST_IDLE`.

Top module: `pgm_port_target`

## Requirements
- R1: After reset `ready_o` is 1. Every flash word reads `0x0000`. EEPROM byte i reads `0xA0 + i`.
- R2: On a rising edge of `load_i`, the bus byte is stored according to `mode_i`. Mode `2'b10` stores it in the command register. Mode `2'b00` stores it in the low address register. Mode `2'b01` stores it in the data register. Mode `2'b11` stores nothing.
- R3: A data load with `bsel_i` = 0 writes the low data byte (bits 7:0 of the word). A data load with `bsel_i` = 1 writes the high byte (bits 15:8). An address load is taken only with `bsel_i` = 0.
- R4: A rising edge of `plat_i` with `bsel_i` = 1 stores the held data word in the page-buffer slot selected by the low log2(PAGE_WORDS) address bits. A rising edge with `bsel_i` = 0 stores nothing.
- R5: A falling edge of `wr_n_i` while the command is `0x10` writes every page-buffer word into the flash page given by address bits above the word index. `ready_o` is then low for exactly PROG_CYC clock cycles. Other pages are not changed.
- R6: When a page write finishes, every page-buffer word becomes `0xFFFF`.
- R7: A falling edge of `wr_n_i` while the command is `0x80` sets every flash word to `0xFFFF`. `ready_o` is then low for exactly ERASE_CYC clock cycles.
- R8: During a chip erase, the EEPROM bytes are kept when `keep_ee_i` = 1 and are set to `0xFF` when `keep_ee_i` = 0.
- R9: While `ready_o` is 0, load, page-latch and write strobes have no effect.
- R10: A falling edge of `wr_n_i` with any command other than `0x80` or `0x10` starts nothing. `ready_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Load target code |
| bsel_i | input | 1 | Byte select: 0 low, 1 high |
| bus_i | input | 8 | Data bus |
| load_i | input | 1 | Load strobe, acts on its rising edge |
| plat_i | input | 1 | Page-latch strobe, acts on its rising edge |
| wr_n_i | input | 1 | Active-low write strobe, acts on its falling edge |
| keep_ee_i | input | 1 | Preserve EEPROM contents during chip erase |
| ready_o | output | 1 | 1 = ready, 0 = operation running |
| peek_sel_i | input | 1 | Inspection target: 0 flash, 1 EEPROM |
| peek_addr_i | input | PEEK_W | Inspection word or byte index |
| peek_data_o | output | 16 | Inspected word; EEPROM bytes are zero-extended |

## Verification
The assertions assume that all strobes and bus inputs are synchronous to `clk` and already free of bounce. Each strobe edge is therefore seen once, on the clock edge that follows the input change. The bench changes every input only at falling clock edges. It holds each strobe level for at least one full cycle, so every edge is seen exactly once. The bench drives the write and load strobes while an operation is running only in the scenario that checks that they are ignored.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [1:0] {
        MODE_ADDR = 2'b00,
        MODE_DATA = 2'b01,
        MODE_CMD  = 2'b10,
        MODE_NONE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG
    } state_e;

    localparam logic [7:0] CMD_ERASE = 8'h80;
    localparam logic [7:0] CMD_WRITE = 8'h10;

endpackage

// File: rtl/pgm_edge.sv
// Registered edge detection for a group of synchronous strobes.
module pgm_edge #(
    parameter int            N       = 3,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise_o[g] = ~prev_q[g] &  sig_i[g];
        assign fall_o[g] =  prev_q[g] & ~sig_i[g];
    end
endmodule

// File: rtl/pgm_loadregs.sv
// Command, address and data holding registers loaded by the load strobe.
module pgm_loadregs
    import pgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_rise,
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       bsel,
    input  logic [7:0] bus,
    output logic [7:0] cmd_o,
    output logic [7:0] addr_o,
    output logic [15:0] word_o
);
    mode_e m;
    logic  take;

    assign m    = mode_e'(mode);
    assign take = load_rise & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o  <= '0;
            addr_o <= '0;
            word_o <= '0;
        end else if (take) begin
            unique case (m)
                MODE_CMD:  cmd_o <= bus;
                MODE_ADDR: if (!bsel) addr_o <= bus;
                MODE_DATA: begin
                    if (bsel) word_o[15:8] <= bus;
                    else      word_o[7:0]  <= bus;
                end
                MODE_NONE: ;
            endcase
        end
    end
endmodule

// File: rtl/pgm_pagebuf.sv
// Page buffer: one slot per word of a flash page.
module pgm_pagebuf #(
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_en,
    input  logic [7:0]          addr,
    input  logic [15:0]         word,
    input  logic                clear,
    output logic [WORDS*16-1:0] buf_o
);
    localparam logic [7:0] IDX_MASK = 8'(WORDS - 1);

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        logic hit;
        assign hit = latch_en && ((addr & IDX_MASK) == 8'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    buf_o[w*16 +: 16] <= 16'hFFFF;
            else if (clear) buf_o[w*16 +: 16] <= 16'hFFFF;
            else if (hit)   buf_o[w*16 +: 16] <= word;
        end
    end
endmodule

// File: rtl/pgm_mem.sv
// Modelled flash (pages of words) and EEPROM (bytes) arrays.
module pgm_mem #(
    parameter int PAGES    = 8,
    parameter int WORDS    = 4,
    parameter int EE_BYTES = 8,
    parameter int PEEK_W   = 5,
    localparam int IDXW    = $clog2(WORDS),
    localparam int FW      = PAGES * WORDS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_go,
    input  logic [7:0]          addr,
    input  logic [WORDS*16-1:0] buf_i,
    input  logic                erase_go,
    input  logic                keep_ee,
    input  logic                peek_sel,
    input  logic [PEEK_W-1:0]   peek_addr,
    output logic [15:0]         peek_data
);
    logic [15:0] flash_q [FW];
    logic [7:0]  ee_q    [EE_BYTES];

    for (genvar i = 0; i < FW; i++) begin : g_flash
        logic sel;
        assign sel = prog_go && ((addr >> IDXW) == 8'(i / WORDS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flash_q[i] <= 16'h0000;
            else if (erase_go) flash_q[i] <= 16'hFFFF;
            else if (sel)      flash_q[i] <= buf_i[(i % WORDS)*16 +: 16];
        end
    end

    for (genvar e = 0; e < EE_BYTES; e++) begin : g_ee
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    ee_q[e] <= 8'hA0 + 8'(e);
            else if (erase_go && !keep_ee) ee_q[e] <= 8'hFF;
        end
    end

    always_comb begin
        peek_data = '0;
        if (peek_sel) begin
            if (int'(peek_addr) < EE_BYTES) peek_data = {8'h00, ee_q[int'(peek_addr)]};
        end else begin
            if (int'(peek_addr) < FW) peek_data = flash_q[int'(peek_addr)];
        end
    end
endmodule

// File: rtl/pgm_ctrl.sv
// Operation sequencer: idle, erase and page-program states.
module pgm_ctrl
    import pgm_pkg::*;
#(
    parameter int ERASE_CYC = 20,
    parameter int PROG_CYC  = 12,
    localparam int MAXC     = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CW       = $clog2(MAXC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_fall,
    input  logic [7:0] cmd,
    output state_e     state_o,
    output logic       ready_o,
    output logic       erase_go,
    output logic       prog_go,
    output logic       buf_clear
);
    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_fall && cmd == CMD_ERASE) begin
                    state_d = ST_ERASE;
                    cnt_d   = CW'(ERASE_CYC - 1);
                end else if (wr_fall && cmd == CMD_WRITE) begin
                    state_d = ST_PROG;
                    cnt_d   = CW'(PROG_CYC - 1);
                end
            end
            ST_ERASE, ST_PROG: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ready_o   = (state_q == ST_IDLE);
        erase_go  = (state_q == ST_IDLE) && wr_fall && (cmd == CMD_ERASE);
        prog_go   = (state_q == ST_IDLE) && wr_fall && (cmd == CMD_WRITE);
        buf_clear = (state_q == ST_PROG) && (cnt_q == '0);
    end

    assign state_o = state_q;
endmodule

// File: rtl/pgm_port_target.sv
module pgm_port_target
    import pgm_pkg::*;
#(
    parameter int PAGES     = 8,
    parameter int WORDS     = 4,
    parameter int EE_BYTES  = 8,
    parameter int ERASE_CYC = 20,
    parameter int PROG_CYC  = 12,
    localparam int FW       = PAGES * WORDS,
    localparam int PEEK_W   = (FW > EE_BYTES) ? $clog2(FW) : $clog2(EE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              bsel_i,
    input  logic [7:0]        bus_i,
    input  logic              load_i,
    input  logic              plat_i,
    input  logic              wr_n_i,
    input  logic              keep_ee_i,
    output logic              ready_o,
    input  logic              peek_sel_i,
    input  logic [PEEK_W-1:0] peek_addr_i,
    output logic [15:0]       peek_data_o
);
    logic [2:0]         rise, fall;
    logic               load_rise, plat_rise, wr_fall;
    logic [7:0]         cmd_q, addr_q;
    logic [15:0]        word_q;
    logic [WORDS*16-1:0] buf_flat;
    logic               erase_go, prog_go, buf_clear;
    state_e             st;

    pgm_edge #(.N(3), .RST_VAL(3'b100)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .sig_i({wr_n_i, plat_i, load_i}),
        .rise_o(rise), .fall_o(fall)
    );

    assign load_rise = rise[0];
    assign plat_rise = rise[1] & ~fall[1];
    assign wr_fall   = fall[2] & ~rise[2];

    pgm_loadregs u_regs (
        .clk(clk), .rst_n(rst_n),
        .load_rise(load_rise), .en(ready_o),
        .mode(mode_i), .bsel(bsel_i), .bus(bus_i),
        .cmd_o(cmd_q), .addr_o(addr_q), .word_o(word_q)
    );

    pgm_pagebuf #(.WORDS(WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .latch_en(plat_rise & bsel_i & ready_o),
        .addr(addr_q), .word(word_q),
        .clear(buf_clear), .buf_o(buf_flat)
    );

    pgm_ctrl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_fall(wr_fall), .cmd(cmd_q),
        .state_o(st), .ready_o(ready_o),
        .erase_go(erase_go), .prog_go(prog_go), .buf_clear(buf_clear)
    );

    pgm_mem #(.PAGES(PAGES), .WORDS(WORDS), .EE_BYTES(EE_BYTES), .PEEK_W(PEEK_W)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .prog_go(prog_go), .addr(addr_q), .buf_i(buf_flat),
        .erase_go(erase_go), .keep_ee(keep_ee_i),
        .peek_sel(peek_sel_i), .peek_addr(peek_addr_i), .peek_data(peek_data_o)
    );
endmodule

// File: rtl/pgm_port_target_chk.sv
module pgm_port_target_chk
    import pgm_pkg::*;
#(
    parameter int BUF_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready_o,
    input logic             wr_fall,
    input logic [7:0]       cmd_q,
    input state_e           state,
    input logic [BUF_W-1:0] buf_flat
);
    // R5 / R7: ready only drops after a write-strobe fall
    p_start_from_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(wr_fall));

    // R9: command register frozen while busy
    p_cmd_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(cmd_q));

    // R6: page buffer all ones right after a page write ends
    p_buf_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state == ST_PROG) && state == ST_IDLE) |-> (&buf_flat));

    // R7: erase never turns straight into a page write
    p_erase_exit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |=> (state != ST_PROG));

    // R10: unknown commands start nothing
    p_bad_cmd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && wr_fall && cmd_q != CMD_ERASE && cmd_q != CMD_WRITE) |=> ready_o);
endmodule

bind pgm_port_target pgm_port_target_chk #(.BUF_W(WORDS*16)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .wr_fall(wr_fall),
    .cmd_q(cmd_q), .state(st), .buf_flat(buf_flat)
);

// File: tb/pgm_port_target_bench.sv
`timescale 1ns/1ps
module pgm_port_target_bench;
    localparam int ERASE_CYC = 20;
    localparam int PROG_CYC  = 12;
    localparam int EE_BYTES  = 8;
    localparam int PW        = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b11;
    logic          bsel_i = 1'b0;
    logic [7:0]    bus_i = '0;
    logic          load_i = 1'b0;
    logic          plat_i = 1'b0;
    logic          wr_n_i = 1'b1;
    logic          keep_ee_i = 1'b0;
    logic          ready_o;
    logic          peek_sel_i = 1'b0;
    logic [PW-1:0] peek_addr_i = '0;
    logic [15:0]   peek_data_o;

    always #2 clk = ~clk;

    pgm_port_target #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_pgm_port_target (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bsel_i(bsel_i), .bus_i(bus_i),
        .load_i(load_i), .plat_i(plat_i), .wr_n_i(wr_n_i), .keep_ee_i(keep_ee_i),
        .ready_o(ready_o), .peek_sel_i(peek_sel_i), .peek_addr_i(peek_addr_i),
        .peek_data_o(peek_data_o)
    );

    typedef struct {
        int    kind;   // 1 = array read, 2 = supplied value
        bit    sel;
        int    addr;
        int    act;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    vectors = 0;
    int    fails   = 0;
    bit    done    = 0;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                int    a;
                it = q.pop_front();
                if (it.kind == 1) begin
                    peek_sel_i  = it.sel;
                    peek_addr_i = PW'(it.addr);
                    #1;
                    a = int'(peek_data_o);
                end else begin
                    a = it.act;
                end
                vectors++;
                if (a !== it.exp) begin
                    fails++;
                    $display("FAIL %s: act=%0h exp=%0h", it.req, a, it.exp);
                end
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic exp_mem(bit sel, int addr, int exp, string req);
        item_t it;
        it.kind = 1; it.sel = sel; it.addr = addr; it.act = 0; it.exp = exp; it.req = req;
        q.push_back(it);
        drain();
    endtask

    task automatic exp_val(int act, int exp, string req);
        item_t it;
        it.kind = 2; it.sel = 0; it.addr = 0; it.act = act; it.exp = exp; it.req = req;
        q.push_back(it);
        drain();
    endtask

    task automatic load_byte(logic [1:0] m, logic b, logic [7:0] d);
        @(negedge clk); mode_i = m; bsel_i = b; bus_i = d;
        @(negedge clk); load_i = 1'b1;
        @(negedge clk); load_i = 1'b0; mode_i = 2'b11;
    endtask

    task automatic page_latch(logic b);
        @(negedge clk); bsel_i = b; plat_i = 1'b1;
        @(negedge clk); plat_i = 1'b0;
    endtask

    // pulses the write strobe and counts falling edges at which ready is low
    task automatic wr_measure(output int n);
        @(negedge clk); wr_n_i = 1'b0;
        @(negedge clk); wr_n_i = 1'b1;
        n = 0;
        while (!ready_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        exp_val(int'(ready_o), 1, "R1 ready after reset");
        exp_mem(0, 0, 16'h0000, "R1 flash reset");
        exp_mem(1, 3, 16'h00A3, "R1 eeprom reset");

        // R2/R3/R4: fill two slots of page 1, one latch with bsel=0 ignored
        load_byte(2'b10, 1'b0, 8'h10);
        load_byte(2'b00, 1'b0, 8'h05);
        load_byte(2'b01, 1'b0, 8'h34);
        load_byte(2'b01, 1'b1, 8'h12);
        load_byte(2'b11, 1'b0, 8'h77);      // R2 mode 11 stores nothing
        page_latch(1'b1);
        load_byte(2'b00, 1'b0, 8'h06);
        load_byte(2'b01, 1'b0, 8'hCD);
        load_byte(2'b01, 1'b1, 8'hAB);
        page_latch(1'b1);
        load_byte(2'b00, 1'b0, 8'h07);
        load_byte(2'b00, 1'b1, 8'h03);      // R3 high address load ignored
        load_byte(2'b01, 1'b0, 8'h66);
        load_byte(2'b01, 1'b1, 8'h55);
        page_latch(1'b0);                   // R4 bsel=0 latch ignored
        wr_measure(n);
        exp_val(n, PROG_CYC, "R5 page write busy length");
        exp_mem(0, 5, 16'h1234, "R2 R3 low/high data word");
        exp_mem(0, 6, 16'hABCD, "R4 latched slot 2");
        exp_mem(0, 4, 16'hFFFF, "R4 unlatched slot 0");
        exp_mem(0, 7, 16'hFFFF, "R4 latch with bsel 0 ignored");
        exp_mem(0, 0, 16'h0000, "R5 other page untouched");

        // R6: writing another page without latching gives all ones
        load_byte(2'b00, 1'b0, 8'h0A);
        wr_measure(n);
        exp_val(n, PROG_CYC, "R6 second page write busy length");
        exp_mem(0, 8, 16'hFFFF, "R6 buffer cleared word 0");
        exp_mem(0, 10, 16'hFFFF, "R6 buffer cleared word 2");
        exp_mem(0, 5, 16'h1234, "R5 page 1 kept");

        // R10: unknown command
        load_byte(2'b10, 1'b0, 8'h22);
        wr_measure(n);
        exp_val(n, 0, "R10 unknown command no busy");
        exp_val(int'(ready_o), 1, "R10 ready stays high");
        exp_mem(0, 0, 16'h0000, "R10 flash unchanged");

        // R7/R8: erase with EEPROM preserved
        keep_ee_i = 1'b1;
        load_byte(2'b10, 1'b0, 8'h80);
        wr_measure(n);
        exp_val(n, ERASE_CYC, "R7 erase busy length");
        exp_mem(0, 0, 16'hFFFF, "R7 flash word 0 erased");
        exp_mem(0, 5, 16'hFFFF, "R7 flash word 5 erased");
        exp_mem(0, 31, 16'hFFFF, "R7 last flash word erased");
        exp_mem(1, 3, 16'h00A3, "R8 eeprom preserved");

        // R9 + R8: erase clearing EEPROM, with strobes injected while busy
        keep_ee_i = 1'b0;
        fork
            wr_measure(n);
            begin
                repeat (3) @(negedge clk);
                load_byte(2'b10, 1'b0, 8'h10);
                @(negedge clk); wr_n_i = 1'b0;
                @(negedge clk); wr_n_i = 1'b1;
            end
        join
        exp_val(n, ERASE_CYC, "R9 strobe while busy ignored");
        for (int e = 0; e < EE_BYTES; e++) exp_mem(1, e, 16'h00FF, "R8 eeprom cleared");
        wr_measure(n);
        exp_val(n, ERASE_CYC, "R9 command load while busy ignored");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (R1..R10 run): act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule